// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block watches the write cycles that arrive on the bus-write side of a NOR-style flash model and turns recognised command sequences into program requests. A sequence opens with two unlock writes at fixed addresses. The third write carries a command byte that starts a program, enters the bypass mode, or enters or leaves the secure-sector mode. Once a program is accepted, the block presents the latched address and the merged data word for one cycle. A behavioural timer then holds the ready output low for the modelled program time.

While the timer runs, every write is dropped except a suspend byte, which only raises a one-cycle flag. In bypass mode each program needs only a command write and a data write. With the high-voltage accelerate input asserted, a single command write followed by the data write starts a faster program, provided the secure sector is not enabled. The array itself sits outside the block: it supplies the word currently stored at the write address, so the block can apply the rule that programming only clears bits.

Top module: `flash_cmd_seq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rdy is 1 and bypass_mode, sec_mode, prog_req, prog_accel and suspend_req are 0.
- R2: The writes AAh at address 555h, 55h at 2AAh and A0h at 555h, followed by a fourth write, make prog_req 1 for exactly the one cycle after that fourth write. In that cycle prog_addr holds the fourth write's address. Address matching uses wr_addr[10:0] and command matching uses wr_data[7:0].
- R3: A write that does not match the next expected cycle of an unlock sequence returns the decoder to read state. A data write that follows such a broken sequence produces no prog_req, and a complete sequence written afterwards works normally.
- R4: The writes AAh@555h, 55h@2AAh and 20h@555h set bypass_mode. In bypass mode a write of A0h at any address, followed by a data write, issues a program, and bypass_mode stays 1 afterwards. A write of F0h clears bypass_mode.
- R5: rdy is 0 for exactly PROG_CYCLES clock cycles, starting in the cycle after the write that starts a standard program. For an accelerated program the count is ACC_CYCLES.
- R6: While rdy is 0, writes do not change the decoder state or the mode outputs and produce no prog_req. A write of B0h during that time makes suspend_req 1 for exactly one cycle.
- R7: With acc_hv at 1 and sec_mode at 0, a single A0h write in read state or in bypass mode, followed by a data write, issues a program with prog_accel at 1. With acc_hv at 0 in read state, or with sec_mode at 1, a lone A0h write followed by a data write issues nothing.
- R8: In the program request, prog_data equals cur_data AND wr_data, and prog_err is 1 exactly when wr_data has a 1 in a bit where cur_data has a 0.
- R9: The writes AAh@555h, 55h@2AAh and 88h@555h set sec_mode. A write of F0h leaves sec_mode unchanged. Only the sequence AAh@555h, 55h@2AAh, 90h@555h, 00h clears sec_mode.
- R10: A hardware reset during a program makes rdy 1 and clears bypass_mode at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | One bus write in this cycle |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data; the low byte is the command code |
| cur_data | input | DW | Word currently stored at wr_addr |
| acc_hv | input | 1 | High-voltage accelerate supply present |
| prog_req | output | 1 | One-cycle program request |
| prog_addr | output | AW | Address of the program request |
| prog_data | output | DW | Word to store (only clears bits) |
| prog_err | output | 1 | The request tried to raise a 0 bit to 1 |
| prog_accel | output | 1 | The request uses the accelerated path |
| rdy | output | 1 | Ready (1) or busy (0) |
| bypass_mode | output | 1 | Bypass mode is active |
| sec_mode | output | 1 | Secure-sector mode is active |
| suspend_req | output | 1 | One-cycle suspend request seen while busy |

## Verification
A corrupted sequence state shows up at the ports no later than the data write that should complete the sequence. The symptom is a missing or an extra prog_req, one cycle after that write. A wrong mode flag is visible at once on bypass_mode or sec_mode. If it changes the program path, it also shows in the length of the rdy low window. A wrong merge or timer count shows on prog_data, prog_err, or the exact cycle where rdy rises again, so the bench samples each of these in the precise cycle after the triggering write.

// File: rtl/flash_cmd_pkg.sv
// Package: shared state type and command / address codes for the
// flash command sequence decoder. Assumes byte-wide command codes in
// the low byte of the data bus and 11-bit unlock address matching.
package flash_cmd_pkg;

    typedef enum logic [2:0] {
        ST_READ  = 3'd0,
        ST_UNL1  = 3'd1,
        ST_UNL2  = 3'd2,
        ST_PDATA = 3'd3,
        ST_BYP   = 3'd4,
        ST_SXIT  = 3'd5
    } seq_state_t;

    localparam logic [7:0]  CMD_UNL1    = 8'hAA;
    localparam logic [7:0]  CMD_UNL2    = 8'h55;
    localparam logic [7:0]  CMD_PROG    = 8'hA0;
    localparam logic [7:0]  CMD_BYP     = 8'h20;
    localparam logic [7:0]  CMD_RST     = 8'hF0;
    localparam logic [7:0]  CMD_SEC_IN  = 8'h88;
    localparam logic [7:0]  CMD_SEC_OUT = 8'h90;
    localparam logic [7:0]  CMD_SEC_END = 8'h00;
    localparam logic [7:0]  CMD_SUSP    = 8'hB0;

    localparam int          MATCH_BITS  = 11;
    localparam logic [10:0] ADR_UNL1    = 11'h555;
    localparam logic [10:0] ADR_UNL2    = 11'h2AA;

endpackage

// File: rtl/fcs_decoder.sv
// Module: fcs_decoder
// Tracks write sequences and holds the mode flags. It raises a
// combinational accept when the data write of a program arrives and the
// block is not busy. Assumes AW >= 11. All writes are dropped while busy,
// except the suspend code, which is reported as a one-cycle pulse.
module fcs_decoder
    import flash_cmd_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          acc_hv,
    input  logic          busy,
    output logic          accept,
    output logic          accel,
    output logic          bypass_mode,
    output logic          sec_mode,
    output logic          suspend_req
);

    seq_state_t             st, st_n;
    logic                   byp_ret, byp_ret_n;
    logic                   accel_n;
    logic                   sec_n;
    logic [7:0]             cmd;
    logic [MATCH_BITS-1:0]  a_lo;
    logic                   live;

    assign cmd  = wr_data[7:0];
    assign a_lo = wr_addr[MATCH_BITS-1:0];
    assign live = wr_en && !busy;

    // Next-state and mode-flag decode for one accepted write.
    always_comb begin
        st_n      = st;
        byp_ret_n = byp_ret;
        accel_n   = accel;
        sec_n     = sec_mode;
        accept    = 1'b0;
        if (live) begin
            if (st != ST_PDATA && cmd == CMD_RST) begin
                st_n      = ST_READ;
                byp_ret_n = 1'b0;
            end else begin
                case (st)
                    ST_READ: begin
                        if (cmd == CMD_UNL1 && a_lo == ADR_UNL1) begin
                            st_n = ST_UNL1;
                        end else if (cmd == CMD_PROG && acc_hv && !sec_mode) begin
                            st_n      = ST_PDATA;
                            byp_ret_n = 1'b0;
                            accel_n   = 1'b1;
                        end
                    end
                    ST_UNL1: begin
                        st_n = (cmd == CMD_UNL2 && a_lo == ADR_UNL2) ? ST_UNL2 : ST_READ;
                    end
                    ST_UNL2: begin
                        st_n = ST_READ;
                        if (a_lo == ADR_UNL1) begin
                            case (cmd)
                                CMD_PROG: begin
                                    st_n      = ST_PDATA;
                                    byp_ret_n = 1'b0;
                                    accel_n   = 1'b0;
                                end
                                CMD_BYP:     st_n  = ST_BYP;
                                CMD_SEC_IN:  sec_n = 1'b1;
                                CMD_SEC_OUT: st_n  = ST_SXIT;
                                default:     st_n  = ST_READ;
                            endcase
                        end
                    end
                    ST_SXIT: begin
                        st_n = ST_READ;
                        if (cmd == CMD_SEC_END) sec_n = 1'b0;
                    end
                    ST_BYP: begin
                        if (cmd == CMD_PROG) begin
                            st_n      = ST_PDATA;
                            byp_ret_n = 1'b1;
                            accel_n   = acc_hv && !sec_mode;
                        end
                    end
                    ST_PDATA: begin
                        accept = 1'b1;
                        st_n   = byp_ret ? ST_BYP : ST_READ;
                    end
                    default: st_n = ST_READ;
                endcase
            end
        end
    end

    // State and flag registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_READ;
            byp_ret  <= 1'b0;
            accel    <= 1'b0;
            sec_mode <= 1'b0;
        end else begin
            st       <= st_n;
            byp_ret  <= byp_ret_n;
            accel    <= accel_n;
            sec_mode <= sec_n;
        end
    end

    // One-cycle pulse for a suspend code written while busy.
    always_ff @(posedge clk) begin
        if (!rst_n) suspend_req <= 1'b0;
        else        suspend_req <= wr_en && busy && (cmd == CMD_SUSP);
    end

    assign bypass_mode = (st == ST_BYP) || (st == ST_PDATA && byp_ret);

endmodule

// File: rtl/fcs_prog_latch.sv
// Module: fcs_prog_latch
// Captures the program request on accept. The stored word is the bitwise
// AND of old and new data, because programming can only clear bits. An
// error flag marks any attempt to raise a 0 to 1. Assumes cur_data is
// valid in the accept cycle.
module fcs_prog_latch #(
    parameter int AW = 12,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic          accel_in,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] cur_data,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          prog_err,
    output logic          prog_accel
);

    logic [DW-1:0] merged;
    logic [DW-1:0] raise;

    // Per-bit merge: keep a bit only where both words hold a 1.
    for (genvar b = 0; b < DW; b++) begin : g_bit
        assign merged[b] = cur_data[b] & wr_data[b];
        assign raise[b]  = wr_data[b] & ~cur_data[b];
    end

    // Request pulse and accel tag, cleared each cycle without accept.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_req   <= 1'b0;
            prog_accel <= 1'b0;
            prog_err   <= 1'b0;
        end else begin
            prog_req   <= accept;
            prog_accel <= accept && accel_in;
            prog_err   <= accept && (|raise);
        end
    end

    // Address and data hold their last value between requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prog_addr <= '0;
            prog_data <= '0;
        end else if (accept) begin
            prog_addr <= wr_addr;
            prog_data <= merged;
        end
    end

endmodule

// File: rtl/fcs_prog_timer.sv
// Module: fcs_prog_timer
// Behavioural model of the embedded program time. A start loads one of
// two cycle counts, and busy stays high until the count reaches zero.
// Assumes start only arrives while the timer is idle.
module fcs_prog_timer #(
    parameter int PROG_CYCLES = 20,
    parameter int ACC_CYCLES  = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic accel,
    output logic busy
);

    localparam int MAXC = (PROG_CYCLES > ACC_CYCLES) ? PROG_CYCLES : ACC_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (start)      cnt <= accel ? CW'(ACC_CYCLES) : CW'(PROG_CYCLES);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

endmodule

// File: rtl/flash_cmd_seq.sv
// Module: flash_cmd_seq (top)
// Connects the sequence decoder, the program request latch and the busy
// timer. Assumes one write per cycle at most and an external array that
// supplies the stored word at wr_addr combinationally.
module flash_cmd_seq #(
    parameter int AW          = 12,
    parameter int DW          = 16,
    parameter int PROG_CYCLES = 20,
    parameter int ACC_CYCLES  = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [DW-1:0] cur_data,
    input  logic          acc_hv,
    output logic          prog_req,
    output logic [AW-1:0] prog_addr,
    output logic [DW-1:0] prog_data,
    output logic          prog_err,
    output logic          prog_accel,
    output logic          rdy,
    output logic          bypass_mode,
    output logic          sec_mode,
    output logic          suspend_req
);

    logic busy;
    logic accept;
    logic accel;

    fcs_decoder #(.AW(AW), .DW(DW)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .acc_hv      (acc_hv),
        .busy        (busy),
        .accept      (accept),
        .accel       (accel),
        .bypass_mode (bypass_mode),
        .sec_mode    (sec_mode),
        .suspend_req (suspend_req)
    );

    fcs_prog_latch #(.AW(AW), .DW(DW)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept     (accept),
        .accel_in   (accel),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .cur_data   (cur_data),
        .prog_req   (prog_req),
        .prog_addr  (prog_addr),
        .prog_data  (prog_data),
        .prog_err   (prog_err),
        .prog_accel (prog_accel)
    );

    fcs_prog_timer #(.PROG_CYCLES(PROG_CYCLES), .ACC_CYCLES(ACC_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (accept),
        .accel (accel),
        .busy  (busy)
    );

    assign rdy = !busy;

endmodule

// File: rtl/fcs_checker.sv
// Module: fcs_checker
// Port-level properties of flash_cmd_seq, attached with bind.
module fcs_checker (
    input logic clk,
    input logic rst_n,
    input logic wr_en,
    input logic prog_req,
    input logic prog_err,
    input logic prog_accel,
    input logic rdy,
    input logic sec_mode,
    input logic suspend_req
);

    logic past_rdy;
    logic past_wr;
    logic past_sec;

    // History registers so that no property reaches before reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_rdy <= 1'b1;
            past_wr  <= 1'b0;
            past_sec <= 1'b0;
        end else begin
            past_rdy <= rdy;
            past_wr  <= wr_en;
            past_sec <= sec_mode;
        end
    end

    assert_req_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> !rdy);

    assert_req_from_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> past_rdy);

    assert_suspend_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        suspend_req |-> !prog_req);

    assert_err_with_req_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_err |-> prog_req);

    assert_accel_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (prog_req && prog_accel) |-> !sec_mode);

    assert_sec_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !past_wr |-> (sec_mode == past_sec));

endmodule

bind flash_cmd_seq fcs_checker u_chk (.*);

// File: tb/flash_cmd_seq_bench.sv
module flash_cmd_seq_bench;

    localparam int AW = 12;
    localparam int DW = 16;
    localparam int PC = 8;
    localparam int AC = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [DW-1:0] cur_data = '1;
    logic          acc_hv = 1'b0;
    logic          prog_req, prog_err, prog_accel, rdy;
    logic          bypass_mode, sec_mode, suspend_req;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    flash_cmd_seq #(.AW(AW), .DW(DW), .PROG_CYCLES(PC), .ACC_CYCLES(AC)) u_flash_cmd_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .cur_data(cur_data), .acc_hv(acc_hv),
        .prog_req(prog_req), .prog_addr(prog_addr), .prog_data(prog_data),
        .prog_err(prog_err), .prog_accel(prog_accel), .rdy(rdy),
        .bypass_mode(bypass_mode), .sec_mode(sec_mode), .suspend_req(suspend_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // One write cycle; returns at the falling edge after the write edge.
    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic unlock();
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
    endtask

    // Counts falling edges with rdy low, starting at the current one.
    task automatic busy_len(output int n);
        n = 0;
        while (!rdy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_ready();
        int n;
        busy_len(n);
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdy", rdy, 1);
        check("R1 bypass", bypass_mode, 0);
        check("R1 sec", sec_mode, 0);
        check("R1 req", prog_req, 0);
        check("R1 suspend", suspend_req, 0);

        // R2/R8 standard program sweep over all nibble pairs
        for (int c = 0; c < 16; c++) begin
            for (int v = 0; v < 16; v++) begin
                unlock();
                wr(12'h555, 16'h00A0);
                cur_data = {4{c[3:0]}};
                wr(AW'(12'h100 + c * 16 + v), {4{v[3:0]}});
                check("R2 req", prog_req, 1);
                check("R2 addr", prog_addr, 32'(12'h100 + c * 16 + v));
                check("R8 data", prog_data, {16'h0, {4{c[3:0] & v[3:0]}}});
                check("R8 err", prog_err, (v & ~c & 15) != 0);
                if (c == 0 && v == 0) begin
                    busy_len(n);
                    check("R5 standard busy", n, PC);
                end else begin
                    @(negedge clk);
                    check("R2 one-cycle", prog_req, 0);
                    wait_ready();
                end
            end
        end
        cur_data = '1;

        // R6 writes during busy are ignored, suspend pulses
        unlock();
        wr(12'h555, 16'h00A0);
        wr(12'h010, 16'h1234);
        wr(12'h555, 16'h00B0);
        check("R6 suspend pulse", suspend_req, 1);
        @(negedge clk);
        check("R6 suspend one-cycle", suspend_req, 0);
        wait_ready();
        unlock();
        wr(12'h555, 16'h00A0);
        wr(12'h011, 16'h0F0F);
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0055);
        wr(12'h555, 16'h0020);
        check("R6 bypass ignored", bypass_mode, 0);
        wait_ready();
        wr(12'h020, 16'h5555);
        check("R6 no req after busy", prog_req, 0);

        // R3 broken sequences
        wr(12'h555, 16'h00AA);
        wr(12'h2AA, 16'h0054);
        wr(12'h555, 16'h00A0);
        wr(12'h030, 16'h1111);
        check("R3 bad unlock2", prog_req, 0);
        wr(12'h555, 16'h00AA);
        wr(12'h2AB, 16'h0055);
        wr(12'h555, 16'h00A0);
        wr(12'h031, 16'h1111);
        check("R3 bad address", prog_req, 0);
        unlock();
        wr(12'h555, 16'h0077);
        wr(12'h032, 16'h1111);
        check("R3 bad command", prog_req, 0);
        unlock();
        wr(12'h555, 16'h00A0);
        wr(12'h033, 16'h2222);
        check("R3 recovery", prog_req, 1);
        wait_ready();

        // R4 bypass mode
        unlock();
        wr(12'h555, 16'h0020);
        check("R4 bypass set", bypass_mode, 1);
        for (int k = 0; k < 8; k++) begin
            wr(AW'(k * 7), 16'h00A0);
            wr(AW'(12'h200 + k), 16'(k * 16'h1111));
            check("R4 bypass req", prog_req, 1);
            check("R4 bypass addr", prog_addr, 32'(12'h200 + k));
            wait_ready();
            check("R4 bypass kept", bypass_mode, 1);
        end
        wr(12'h000, 16'h00F0);
        check("R4 bypass cleared", bypass_mode, 0);
        wr(12'h000, 16'h00A0);
        wr(12'h040, 16'h1234);
        check("R7 no accel without hv", prog_req, 0);

        // R7 accelerated program
        acc_hv = 1'b1;
        wr(12'h000, 16'h00A0);
        wr(12'h041, 16'h4321);
        check("R7 accel req", prog_req, 1);
        check("R7 accel flag", prog_accel, 1);
        busy_len(n);
        check("R5 accel busy", n, AC);

        // R9 secure mode, R7 gate under secure mode
        unlock();
        wr(12'h555, 16'h0088);
        check("R9 sec set", sec_mode, 1);
        wr(12'h000, 16'h00A0);
        wr(12'h042, 16'h1234);
        check("R7 blocked by sec", prog_req, 0);
        wr(12'h000, 16'h00F0);
        check("R9 F0 keeps sec", sec_mode, 1);
        unlock();
        wr(12'h555, 16'h0090);
        wr(12'h000, 16'h0000);
        check("R9 sec cleared", sec_mode, 0);
        acc_hv = 1'b0;

        // R10 hardware reset during a bypass program
        unlock();
        wr(12'h555, 16'h0020);
        wr(12'h000, 16'h00A0);
        wr(12'h050, 16'h0001);
        check("R10 busy before reset", rdy, 0);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R10 rdy after reset", rdy, 1);
        check("R10 bypass after reset", bypass_mode, 0);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule